// File: doc/BRIEF.md
# AXI ID Masked Match Count Qualifier

This block sits in front of a bank of event counters inside a memory controller performance monitor. For each counter lane it watches the read and write channels of one AXI port and decides, every cycle, how much that lane's counter should advance. A transaction is qualified when its ID, after masking, equals the lane's programmed ID under the same mask. It must also travel in the direction the lane selects and be seen on the monitored port.

Each lane chooses whether it qualifies on address-channel handshakes or on data-channel handshakes. It also chooses whether it counts bursts (an increment of one) or bytes (an increment of two to the power of the transfer size). For data-channel counting, the transfer size is taken from the matching address phase. A matching write burst opens a window in which write data beats are counted, because write data carries no ID. A build parameter selects either one ID/mask pair shared by every lane or an independent pair per lane. The increment leaves the block through a register, so it appears one cycle after the handshake that caused it. Counter storage is outside this block.

Top module: `axi_idq_filter`

## Requirements
- R1: A transaction matches a lane when (transaction ID AND mask) equals (lane ID AND mask). A mask bit of 1 makes that ID bit take part in the compare; a mask bit of 0 makes the bit irrelevant.
- R2: The lane event code selects the direction: 2'b01 counts only read traffic and 2'b10 counts only write traffic. 2'b00 and 2'b11 never produce an increment.
- R3: With channel select 0, a lane qualifies only on address handshakes (ar_valid && ar_ready for reads, aw_valid && aw_ready for writes). A valid without ready produces nothing.
- R4: With channel select 1, a lane ignores address handshakes and qualifies on data beats (r_valid && r_ready with a matching r_id, or w_valid && w_ready inside an open write burst). In burst mode only the beat flagged last counts.
- R5: With the bytes flag 0 the increment is 1. With the bytes flag 1 the increment is 2**size, where size is the 3-bit AxSIZE of the address handshake itself (channel 0) or of the latest matching address handshake in that direction (channel 1).
- R6: When mon_port is not 0, no lane produces an increment.
- R7: cnt_inc is registered: it is zero during and right after reset, and a qualified handshake shows on cnt_inc exactly one cycle later, for one cycle.
- R8: A matching aw handshake opens a write burst for that lane. A write beat with w_last closes it. Write beats outside an open burst are not counted.
- R9: With SHARED_FILTER=1, every lane compares against the ID and mask of lane 0 and ignores its own ID/mask fields. With SHARED_FILTER=0, each lane uses its own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_port | input | PORT_W | Port number of the observed traffic; only 0 is counted |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read address ID |
| ar_size | input | SIZE_W | Read transfer size (log2 bytes) |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| aw_size | input | SIZE_W | Write transfer size (log2 bytes) |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | ID_W | Read data ID |
| r_last | input | 1 | Last read beat |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Last write beat |
| cfg_evt | input | 2*NUM_CNT | Per-lane event code, 2 bits per lane |
| cfg_chan | input | NUM_CNT | Per-lane channel select, 0 address, 1 data |
| cfg_bytes | input | NUM_CNT | Per-lane bytes flag, 1 counts bytes |
| cfg_id | input | ID_W*NUM_CNT | Per-lane compare ID |
| cfg_mask | input | ID_W*NUM_CNT | Per-lane compare mask |
| cnt_inc | output | (2**SIZE_W)*NUM_CNT | Per-lane registered increment |

## Verification
On every cycle, assertions check that a non-zero port, a disabled event code or a burst-mode lane never produces an increment above its allowed value. They also check that an address-mode lane stays silent without an address handshake and that every increment is zero or a single power of two. The ID compare itself, the sizes latched from address phases, and the opening and closing of write bursts depend on sequences of traffic. Only the bench's scenarios show these: the sweeps over IDs and sizes, the multi-beat bursts and the shared-filter instance.

// File: rtl/axi_idq_pkg.sv
package axi_idq_pkg;
  typedef enum logic [1:0] {
    EVT_OFF   = 2'b00,
    EVT_READ  = 2'b01,
    EVT_WRITE = 2'b10,
    EVT_RSVD  = 2'b11
  } evt_e;
endpackage

// File: rtl/axi_idq_match.sv
module axi_idq_match #(
  parameter int ID_W = 16
) (
  input  logic [ID_W-1:0] txn_id,
  input  logic [ID_W-1:0] ref_id,
  input  logic [ID_W-1:0] ref_mask,
  output logic            hit
);
  assign hit = ((txn_id ^ ref_id) & ref_mask) == '0;
endmodule

// File: rtl/axi_idq_lane.sv
module axi_idq_lane
  import axi_idq_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int SIZE_W = 3,
  parameter int PORT_W = 2,
  localparam int INC_W = 1 << SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] mon_port,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [SIZE_W-1:0] ar_size,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [SIZE_W-1:0] aw_size,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  input  logic              r_last,
  input  logic              w_valid,
  input  logic              w_ready,
  input  logic              w_last,
  input  evt_e              evt,
  input  logic              chan,
  input  logic              bytes,
  input  logic [ID_W-1:0]   flt_id,
  input  logic [ID_W-1:0]   flt_mask,
  output logic [INC_W-1:0]  inc_o
);
  logic ar_m, aw_m, r_m;
  logic ar_hit, aw_hit, r_beat, w_hs, w_beat, port_ok;
  logic [SIZE_W-1:0] rd_size_q, rd_size_d, wr_size_q, wr_size_d;
  logic [SIZE_W-1:0] rd_sz_cur, wr_sz_cur, sel_sz;
  logic wr_open_q, wr_open_d, wr_open_cur;
  logic trk_en, fire;
  logic [INC_W-1:0] inc_d, inc_q;

  axi_idq_match #(.ID_W(ID_W)) u_ar_m (.txn_id(ar_id), .ref_id(flt_id), .ref_mask(flt_mask), .hit(ar_m));
  axi_idq_match #(.ID_W(ID_W)) u_aw_m (.txn_id(aw_id), .ref_id(flt_id), .ref_mask(flt_mask), .hit(aw_m));
  axi_idq_match #(.ID_W(ID_W)) u_r_m  (.txn_id(r_id),  .ref_id(flt_id), .ref_mask(flt_mask), .hit(r_m));

  assign port_ok     = (mon_port == '0);
  assign ar_hit      = ar_valid && ar_ready && ar_m;
  assign aw_hit      = aw_valid && aw_ready && aw_m;
  assign r_beat      = r_valid && r_ready && r_m;
  assign w_hs        = w_valid && w_ready;
  assign wr_open_cur = wr_open_q || aw_hit;
  assign w_beat      = w_hs && wr_open_cur;
  assign rd_sz_cur   = ar_hit ? ar_size : rd_size_q;
  assign wr_sz_cur   = aw_hit ? aw_size : wr_size_q;

  // qualification and increment
  always_comb begin
    fire   = 1'b0;
    sel_sz = '0;
    unique case (evt)
      EVT_READ: begin
        if (!chan) begin
          fire   = ar_hit;
          sel_sz = ar_size;
        end else begin
          fire   = r_beat && (bytes || r_last);
          sel_sz = rd_sz_cur;
        end
      end
      EVT_WRITE: begin
        if (!chan) begin
          fire   = aw_hit;
          sel_sz = aw_size;
        end else begin
          fire   = w_beat && (bytes || w_last);
          sel_sz = wr_sz_cur;
        end
      end
      default: begin
        fire   = 1'b0;
        sel_sz = '0;
      end
    endcase
    if (fire && port_ok)
      inc_d = bytes ? (INC_W'(1) << sel_sz) : INC_W'(1);
    else
      inc_d = '0;
  end

  // burst tracking next state
  always_comb begin
    trk_en    = ar_hit || aw_hit || (w_hs && w_last);
    rd_size_d = rd_sz_cur;
    wr_size_d = wr_sz_cur;
    if (aw_hit)
      wr_open_d = 1'b1;
    else if (w_hs && w_last)
      wr_open_d = 1'b0;
    else
      wr_open_d = wr_open_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_size_q <= '0;
      wr_size_q <= '0;
      wr_open_q <= 1'b0;
    end else if (trk_en) begin
      rd_size_q <= rd_size_d;
      wr_size_q <= wr_size_d;
      wr_open_q <= wr_open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inc_q <= '0;
    else        inc_q <= inc_d;
  end

  assign inc_o = inc_q;

  AST_INC_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc_q)); // R5
  AST_PORT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_port != '0) |=> (inc_q == '0)); // R6
  AST_EVT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EVT_OFF || evt == EVT_RSVD) |=> (inc_q == '0)); // R2
  AST_BURST_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bytes) |=> (inc_q <= INC_W'(1))); // R5
  AST_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan && !(ar_valid && ar_ready) && !(aw_valid && aw_ready)) |=> (inc_q == '0)); // R3
endmodule

// File: rtl/axi_idq_filter.sv
module axi_idq_filter
  import axi_idq_pkg::*;
#(
  parameter int NUM_CNT       = 4,
  parameter int ID_W          = 16,
  parameter int SIZE_W        = 3,
  parameter int PORT_W        = 2,
  parameter bit SHARED_FILTER = 1'b0,
  localparam int INC_W = 1 << SIZE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PORT_W-1:0]       mon_port,
  input  logic                    ar_valid,
  input  logic                    ar_ready,
  input  logic [ID_W-1:0]         ar_id,
  input  logic [SIZE_W-1:0]       ar_size,
  input  logic                    aw_valid,
  input  logic                    aw_ready,
  input  logic [ID_W-1:0]         aw_id,
  input  logic [SIZE_W-1:0]       aw_size,
  input  logic                    r_valid,
  input  logic                    r_ready,
  input  logic [ID_W-1:0]         r_id,
  input  logic                    r_last,
  input  logic                    w_valid,
  input  logic                    w_ready,
  input  logic                    w_last,
  input  logic [2*NUM_CNT-1:0]    cfg_evt,
  input  logic [NUM_CNT-1:0]      cfg_chan,
  input  logic [NUM_CNT-1:0]      cfg_bytes,
  input  logic [ID_W*NUM_CNT-1:0] cfg_id,
  input  logic [ID_W*NUM_CNT-1:0] cfg_mask,
  output logic [INC_W*NUM_CNT-1:0] cnt_inc
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
    logic [ID_W-1:0] lid, lmask;
    if (SHARED_FILTER) begin : g_shared
      assign lid   = cfg_id[ID_W-1:0];
      assign lmask = cfg_mask[ID_W-1:0];
    end else begin : g_own
      assign lid   = cfg_id[g*ID_W +: ID_W];
      assign lmask = cfg_mask[g*ID_W +: ID_W];
    end
    axi_idq_lane #(.ID_W(ID_W), .SIZE_W(SIZE_W), .PORT_W(PORT_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .mon_port(mon_port),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_size(ar_size),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_size(aw_size),
      .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_last(r_last),
      .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
      .evt(evt_e'(cfg_evt[2*g +: 2])), .chan(cfg_chan[g]), .bytes(cfg_bytes[g]),
      .flt_id(lid), .flt_mask(lmask),
      .inc_o(cnt_inc[g*INC_W +: INC_W])
    );
  end
endmodule

// File: tb/axi_idq_filter_test.sv
module axi_idq_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, IDW = 16, SW = 3, PW = 2, IW = 8;

  logic clk = 0, rst_n;
  logic [PW-1:0] mon_port;
  logic ar_valid, ar_ready, aw_valid, aw_ready, r_valid, r_ready, r_last;
  logic w_valid, w_ready, w_last;
  logic [IDW-1:0] ar_id, aw_id, r_id;
  logic [SW-1:0] ar_size, aw_size;
  logic [2*N-1:0] cfg_evt;
  logic [N-1:0] cfg_chan, cfg_bytes;
  logic [IDW*N-1:0] cfg_id, cfg_mask;
  logic [IW*N-1:0] cnt_inc, cnt_inc_sh;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_idq_filter uut (.*);
  axi_idq_filter #(.SHARED_FILTER(1'b1)) uut_shared (
    .clk(clk), .rst_n(rst_n), .mon_port(mon_port),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_size(ar_size),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_size(aw_size),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_last(r_last),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .cfg_evt(cfg_evt), .cfg_chan(cfg_chan), .cfg_bytes(cfg_bytes),
    .cfg_id(cfg_id), .cfg_mask(cfg_mask), .cnt_inc(cnt_inc_sh));

  task automatic chk(input string req, input int lane, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s lane %0d actual %0d expected %0d", req, lane, got, exp);
    end
  endtask

  function automatic int inc_of(input int lane);
    return int'(cnt_inc[lane*IW +: IW]);
  endfunction

  task automatic set_lane(input int l, input logic [1:0] e, input logic c, input logic b,
                          input logic [15:0] id, input logic [15:0] m);
    cfg_evt[2*l +: 2] = e; cfg_chan[l] = c; cfg_bytes[l] = b;
    cfg_id[l*IDW +: IDW] = id; cfg_mask[l*IDW +: IDW] = m;
  endtask

  task automatic idle();
    ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0;
    r_valid = 0; r_ready = 0; r_last = 0; w_valid = 0; w_ready = 0; w_last = 0;
  endtask

  // inputs are held for one posedge; result is sampled at the following negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect4(input string req, input int e0, input int e1, input int e2, input int e3);
    chk(req, 0, inc_of(0), e0); chk(req, 1, inc_of(1), e1);
    chk(req, 2, inc_of(2), e2); chk(req, 3, inc_of(3), e3);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; mon_port = 0; idle();
    ar_id = 0; aw_id = 0; r_id = 0; ar_size = 0; aw_size = 0;
    cfg_evt = 0; cfg_chan = 0; cfg_bytes = 0; cfg_id = 0; cfg_mask = 0;
    repeat (3) @(negedge clk);
    expect4("R7 reset", 0, 0, 0, 0);
    rst_n = 1;
    step();
    expect4("R7 after reset", 0, 0, 0, 0);

    // R1: ID sweep on read address handshakes
    set_lane(0, 2'b00, 0, 0, 16'h0005, 16'hFFFF);
    set_lane(1, 2'b01, 0, 0, 16'h0005, 16'h000F);
    set_lane(2, 2'b01, 0, 0, 16'hFFFF, 16'h0000);
    set_lane(3, 2'b01, 0, 0, 16'h0003, 16'hFFFF);
    for (int id = 0; id < 32; id++) begin
      ar_valid = 1; ar_ready = 1; ar_id = 16'(id); ar_size = 0;
      step();
      expect4("R1 id match", 0, ((id & 15) == 5) ? 1 : 0, 1, (id == 3) ? 1 : 0);
      idle();
      step();
      expect4("R7 single cycle", 0, 0, 0, 0);
    end

    // R3: valid without ready
    ar_valid = 1; ar_ready = 0; ar_id = 5;
    step();
    expect4("R3 no handshake", 0, 0, 0, 0);
    idle();

    // R2: write traffic to read lanes, then a write lane
    aw_valid = 1; aw_ready = 1; aw_id = 5; aw_size = 0;
    step();
    expect4("R2 read lanes ignore write", 0, 0, 0, 0);
    idle();
    set_lane(1, 2'b10, 0, 0, 16'h0005, 16'h000F);
    set_lane(2, 2'b11, 0, 0, 16'h0000, 16'h0000);
    aw_valid = 1; aw_ready = 1; aw_id = 5;
    step();
    expect4("R2 write lane / reserved code", 0, 1, 0, 0);
    idle();
    step();
    aw_valid = 1; aw_ready = 1; aw_id = 7;  // close-out not needed in address mode
    idle();

    // R5: size sweep, byte mode on address channel
    set_lane(1, 2'b01, 0, 1, 16'h0000, 16'h0000);
    set_lane(2, 2'b01, 0, 0, 16'h0000, 16'h0000);
    set_lane(3, 2'b00, 0, 0, 16'h0000, 16'h0000);
    for (int s = 0; s < 8; s++) begin
      ar_valid = 1; ar_ready = 1; ar_id = 16'h1234; ar_size = 3'(s);
      step();
      expect4("R5 bytes per size", 0, 1 << s, 1, 0);
      idle();
    end

    // R6: non-zero port blocks
    for (int p = 1; p < 4; p++) begin
      mon_port = 2'(p);
      ar_valid = 1; ar_ready = 1; ar_id = 0; ar_size = 2;
      step();
      expect4("R6 port gate", 0, 0, 0, 0);
      idle();
    end
    mon_port = 0;

    // R4 / R5 / R8: data-channel lanes
    set_lane(0, 2'b10, 1, 0, 16'h0005, 16'h000F);
    set_lane(1, 2'b01, 1, 1, 16'h0005, 16'h000F);
    set_lane(2, 2'b01, 1, 0, 16'h0005, 16'h000F);
    set_lane(3, 2'b10, 1, 1, 16'h0005, 16'h000F);
    ar_valid = 1; ar_ready = 1; ar_id = 5; ar_size = 2;
    step();
    expect4("R4 address ignored in data mode", 0, 0, 0, 0);
    idle();
    for (int b = 0; b < 3; b++) begin
      r_valid = 1; r_ready = 1; r_id = 16'h0015; r_last = (b == 2);
      step();
      expect4("R4 R5 read beats", 0, 4, (b == 2) ? 1 : 0, 0);
      idle();
    end
    r_valid = 1; r_ready = 1; r_id = 6; r_last = 1;
    step();
    expect4("R1 read beat other id", 0, 0, 0, 0);
    idle();
    aw_valid = 1; aw_ready = 1; aw_id = 5; aw_size = 1;
    step();
    expect4("R4 aw ignored in data mode", 0, 0, 0, 0);
    idle();
    for (int b = 0; b < 2; b++) begin
      w_valid = 1; w_ready = 1; w_last = (b == 1);
      step();
      expect4("R8 R5 write beats", (b == 1) ? 1 : 0, 0, 0, 2);
      idle();
    end
    w_valid = 1; w_ready = 1; w_last = 1;
    step();
    expect4("R8 beat after close", 0, 0, 0, 0);
    idle();
    aw_valid = 1; aw_ready = 1; aw_id = 6; aw_size = 3;
    step();
    idle();
    w_valid = 1; w_ready = 1; w_last = 1;
    step();
    expect4("R8 unmatched burst", 0, 0, 0, 0);
    idle();

    // R9: shared versus per-lane filter
    set_lane(0, 2'b00, 0, 0, 16'h0005, 16'h000F);
    set_lane(1, 2'b01, 0, 0, 16'h0003, 16'hFFFF);
    set_lane(2, 2'b00, 0, 0, 16'h0000, 16'h0000);
    set_lane(3, 2'b00, 0, 0, 16'h0000, 16'h0000);
    ar_valid = 1; ar_ready = 1; ar_id = 5; ar_size = 0;
    step();
    chk("R9 own filter id5", 1, inc_of(1), 0);
    chk("R9 shared filter id5", 1, int'(cnt_inc_sh[IW +: IW]), 1);
    ar_id = 3;
    step();
    chk("R9 own filter id3", 1, inc_of(1), 1);
    chk("R9 shared filter id3", 1, int'(cnt_inc_sh[IW +: IW]), 0);
    idle();
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule